// File: doc/BRIEF.md
# Packed Signed-Digit Sequential Multiplier

This block multiplies two signed numbers over several clock cycles. One operand, the multiplicand, arrives in a packed signed-digit form. In a canonic signed-digit number no two neighbouring digits are both nonzero, so the bit just above every nonzero digit is free to carry that digit's sign. The packed word is therefore only one bit wider than the plain two's-complement operand. The other operand, the multiplier, is an ordinary two's-complement word.

After a start request, the block registers both operands and unpacks the packed word into a vector of signed digits. It then walks those digits from the most significant to the least significant, one per cycle, using a Horner recurrence: the accumulator is doubled, then the multiplier is added for a +1 digit, subtracted for a -1 digit, or left alone for a zero digit. The result is the exact 2W-bit signed product. It stays on the output until the next accepted start.

Top module: `sdmul_top`

## Requirements
- R1: A start pulse seen while idle registers both operands, raises busy, and clears the product output to zero on the following cycle.
- R2: Packed multiplicand layout. Scanning from bit 0 upward, a set bit that is not already claimed as a sign marks a nonzero digit at that position. The bit directly above it is that digit's sign (0 = +1, 1 = -1) and is consumed. Bit W serves only as a sign slot. Digits exist at positions 0..W-1.
- R3: A zero digit contributes nothing. A multiplicand of all zero digits gives a product of zero.
- R4: A +1 digit at position i adds the multiplier times 2^i to the product.
- R5: A -1 digit at position i subtracts the multiplier times 2^i from the product.
- R6: The multiplier is two's complement and is sign-extended to 2W bits. For every multiplicand value in the W-bit signed range, packed in non-adjacent form, the product equals the exact signed product. This includes zero, the most negative value and all ones.
- R7: busy stays high for exactly W+1 cycles: one unpack cycle and W digit steps. done is a single-cycle pulse in the cycle after busy falls, and busy and done are never high together.
- R8: A start request while busy is ignored: the registered operands do not change and the result is that of the operation in progress. While idle and without a start, the product output holds its value.
- R9: A synchronous active-high reset sets busy, done and the product to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication (accepted only while idle) |
| mcand_pk | input | W+1 | Multiplicand in packed signed-digit form |
| mplier | input | W | Multiplier, two's complement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2W | Signed product, registered |

## Verification
The assertions check the properties that hold on every cycle:
- done never coincides with busy and never lasts more than one cycle.
- busy only falls into a done pulse.
- an accepted start clears the product.
- the registered operands stay frozen while busy.
- the product holds while idle.

Only the bench's scenarios can show the arithmetic itself: the unpacking of sign slots, the add, subtract and skip of each digit, and exact products across the full signed range. They also show the exact W+1-cycle latency and that a start arriving mid-operation leaves the result unchanged.

// File: rtl/sdmul_pkg.sv
package sdmul_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_UNPACK = 2'd1,
    PH_WALK   = 2'd2
  } phase_t;
endpackage

// File: rtl/sd_unpack.sv
// Unpacks a packed signed-digit word: a set bit not already claimed as a
// sign marks a nonzero digit; the next bit up carries its sign.
module sd_unpack #(
  parameter int W = 8
) (
  input  logic [W:0]   pk,
  output logic [W-1:0] nz,
  output logic [W-1:0] neg
);
  logic [W:0] claimed;

  always_comb begin
    claimed    = '0;
    nz         = '0;
    neg        = '0;
    for (int i = 0; i < W; i++) begin
      nz[i]          = pk[i] & ~claimed[i];
      neg[i]         = pk[i+1];
      claimed[i+1]   = nz[i];
    end
  end
endmodule

// File: rtl/sd_step.sv
// One Horner step: next = 2*acc + digit*operand, operand sign-extended.
module sd_step #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] acc,
  input  logic [W-1:0]   opnd,
  input  logic           nz,
  input  logic           neg,
  output logic [2*W-1:0] nxt
);
  localparam int PW = 2 * W;
  logic [PW-1:0] ext;
  logic [PW-1:0] term;

  always_comb begin
    ext  = {{W{opnd[W-1]}}, opnd};
    if (!nz)      term = '0;
    else if (neg) term = PW'(0) - ext;
    else          term = ext;
    nxt  = {acc[PW-2:0], 1'b0} + term;
  end
endmodule

// File: rtl/sdmul_top.sv
module sdmul_top
  import sdmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W:0]     mcand_pk,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int PW = 2 * W;
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  phase_t          phase;
  logic [W-1:0]    op_q;
  logic [W:0]      pk_q;
  logic [W-1:0]    nz_q, neg_q;
  logic [W-1:0]    nz_w, neg_w;
  logic [CW-1:0]   idx;
  logic [PW-1:0]   step_w;

  sd_unpack #(.W(W)) i_unpack (
    .pk  (pk_q),
    .nz  (nz_w),
    .neg (neg_w)
  );

  sd_step #(.W(W)) i_step (
    .acc  (product),
    .opnd (op_q),
    .nz   (nz_q[idx]),
    .neg  (neg_q[idx]),
    .nxt  (step_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
      op_q    <= '0;
      pk_q    <= '0;
      nz_q    <= '0;
      neg_q   <= '0;
      idx     <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            op_q    <= mplier;
            pk_q    <= mcand_pk;
            product <= '0;
            busy    <= 1'b1;
            phase   <= PH_UNPACK;
          end
        end
        PH_UNPACK: begin
          nz_q  <= nz_w;
          neg_q <= neg_w;
          idx   <= CW'(W - 1);
          phase <= PH_WALK;
        end
        PH_WALK: begin
          product <= step_w;
          if (idx == '0) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdmul_chk.sv
module sdmul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product,
  input logic [W-1:0]   op_q
);
  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_one_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (product == '0));

  p_op_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !$rose(busy)) |-> $stable(op_q));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));
endmodule

bind sdmul_top sdmul_chk #(.W(W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product),
  .op_q    (op_q)
);

// File: tb/test_sdmul_top.sv
module test_sdmul_top;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W:0]    mcand_pk = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sdmul_top #(.W(W)) i_sdmul_top (
    .clk(clk), .rst(rst), .start(start), .mcand_pk(mcand_pk),
    .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: run hung, got cyc=%0d expected < 100000", cyc);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Non-adjacent form packing: sign of digit i stored in bit i+1.
  function automatic logic [W:0] pack(input int v);
    logic [W:0] r = '0;
    int x = v;
    for (int i = 0; i < W; i++) begin
      if (x % 2 != 0) begin
        int m = ((x % 4) + 4) % 4;
        r[i] = 1'b1;
        if (m == 1) x = x - 1;
        else begin
          r[i+1] = 1'b1;
          x = x + 1;
        end
      end
      x = x / 2;
    end
    return r;
  endfunction

  function automatic longint sx(input logic [PW-1:0] p);
    return longint'($signed(p));
  endfunction

  // Runs one multiplication; checks latency, clear and result.
  task automatic run(input string tag, input logic [W:0] pk, input int op,
                     input longint exp, input bit poke);
    int n = 0;
    mcand_pk = pk;
    mplier   = W'(op);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (tag == "R1") begin
      check("R1 busy", busy, 1);
      check("R1 clear", sx(product), 0);
    end
    while (!done && n < 50) begin
      if (poke && n == 2) begin
        mcand_pk = pack(1);
        mplier   = W'(1);
        start    = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    if (tag == "R7") check("R7 latency", n, W + 2);
    check(tag, sx(product), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 product", sx(product), 0);
    rst = 1'b0;
    @(negedge clk);

    run("R1", pack(3), 5, 15, 0);
    run("R3", '0, -7, 0, 0);
    run("R4", 5'b00100, 3, 12, 0);
    run("R5", 5'b01100, 3, -12, 0);
    run("R2", 5'b01110, -5, -30, 0);
    run("R2", 5'b00011, 7, -7, 0);
    run("R7", pack(-8), -8, 64, 0);
    run("R8", pack(7), -3, -21, 1);
    repeat (3) @(negedge clk);
    check("R8 idle hold", sx(product), -21);

    for (int a = -(1 << (W-1)); a < (1 << (W-1)); a++)
      for (int b = -(1 << (W-1)); b < (1 << (W-1)); b++)
        run("R6", pack(a), b, longint'(a * b), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule